// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Responder

This block models a byte-organised serial EEPROM reached over a two-wire clock/data line pair. A host does not drive the wires directly: it posts a write strobe carrying the new clock and data levels, and a read strobe whenever it wants the level the memory presents on the data line. From the sequence of posted levels the block recognises start and stop conditions, counts clock periods within a transfer, collects device and word address bits, shifts data bits into its internal array and presents stored bits back, most significant bit first.

Three device variants share one bit-period counter and are chosen by a static mode input (value 0: small legacy device, 1: one word-address byte, 2 or 3: two word-address bytes). In the legacy variant the first byte carries a 7-bit word address followed by the direction bit; in the other two a device byte comes first and its least significant bit selects reading. Write bursts roll over inside a page (4 bytes for legacy, 16 bytes otherwise), while read bursts advance through the whole address space. Address bits above the array size alias onto the array.

Top module: `twoline_eeprom`

## Requirements
- R1: With the clock level 1 on both the stored and the newly posted sample, a data change 1→0 is a start (transfer active, bit counter 0) and a data change 0→1 is a stop (transfer inactive).
- R2: While a transfer is active, each clock rise (0→1) advances the bit counter and each clock fall (1→0) latches the posted data level; while inactive, clock activity changes no stored state.
- R3: The counter rolls back from 18 to 9 in legacy mode and in reads of the other modes, from 27 to 18 for writes with one address byte, and from 36 to 27 for writes with two address bytes, so multi-byte bursts continue indefinitely.
- R4: Periods 9, 18 and 27 are acknowledge periods: nothing is latched in them and a read in one of them returns 0.
- R5: In legacy mode (mode 0) periods 1 to 8 carry a 7-bit word address, MSB first, then the direction bit (1 = read).
- R6: A legacy write shifts eight data bits MSB first into the addressed byte; after each byte only word-address bits 1:0 advance, forming a 4-byte page.
- R7: A legacy read returns the addressed byte in periods 10 to 17, MSB first; after each byte the word address advances by one, rolling over from 127 to 0.
- R8: In mode 1 periods 1 to 8 carry a device byte (bit 0 = 1 selects read) and periods 10 to 17 the word address; the word address then takes bits 10:8 from device-byte bits 3:1.
- R9: In mode 2 (and 3) the device byte is followed by two address bytes, high byte first, forming a 13-bit address.
- R10: In modes 1 and 2 each written byte advances only address bits 3:0, forming a 16-byte page.
- R11: In modes 1 and 2 each read byte advances the full 13-bit address, crossing page boundaries.
- R12: A read with no transfer active, or in a period that carries no stored bit, returns the data level last posted by the host.
- R13: A read while the posted clock is 0 and at least EARLY_GAP clock cycles after the last write strobe is answered as if the next bit period had already begun.
- R14: rd_data is registered: it is 0 after reset, takes its new value on the edge that samples rd_stb, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Device variant (0 legacy, 1 one address byte, 2/3 two address bytes), static during transfers |
| wr_stb | input | 1 | Host posts new line levels this cycle |
| wr_scl | input | 1 | Posted clock-line level |
| wr_sda | input | 1 | Posted data-line level |
| rd_stb | input | 1 | Host samples the data line this cycle |
| rd_data | output | 1 | Data-line level answered to the last read strobe |

## Verification
The bench aims at the page boundaries: a legacy burst of six bytes from word 5 must fold back to word 4, and a sixteen-byte-page burst must fold at the page edge, so a design that carried into higher address bits would corrupt a neighbouring page that a later read exposes. Sequential reads across the 127→0 legacy rollover and across a 256-byte boundary in mode 1 catch a design that masked the read increment like the write increment. The early-read rule is tested both ways at the same bit, so answering early too soon or never shows up as a wrong bit, and reads in acknowledge periods and idle reads catch a design that leaked stored data or a stale level onto the line.

// File: rtl/twe_pkg.sv
package twe_pkg;

    localparam int CYC_W   = 6;
    localparam int ADDR_W  = 13;
    localparam int SLAVE_W = 4;

    typedef enum logic [1:0] {
        MODE_LEGACY  = 2'd0,
        MODE_ONE     = 2'd1,
        MODE_TWO     = 2'd2,
        MODE_TWO_ALT = 2'd3
    } twe_mode_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } line_evt_t;

    function automatic logic is_ack_slot(input logic [CYC_W-1:0] c);
        return (c == 6'd9) || (c == 6'd18) || (c == 6'd27);
    endfunction

    function automatic logic [ADDR_W-1:0] page16_next(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:4], a[3:0] + 4'd1};
    endfunction

    function automatic logic [7:0] legacy_page_next(input logic [7:0] a);
        return {a[7:3], a[2:1] + 2'd1, a[0]};
    endfunction

    function automatic logic [CYC_W-1:0] wrap_point(input twe_mode_e m);
        case (m)
            MODE_LEGACY: return 6'd18;
            MODE_ONE:    return 6'd27;
            default:     return 6'd36;
        endcase
    endfunction

endpackage

// File: rtl/twe_line_mon.sv
module twe_line_mon
    import twe_pkg::*;
#(
    parameter int EARLY_GAP = 24,
    localparam int GAP_W = $clog2(EARLY_GAP + 1)
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_stb,
    input  logic      scl_in,
    input  logic      sda_in,
    output line_evt_t evt,
    output logic      scl_q,
    output logic      sda_q,
    output logic      gap_met
);

    logic [GAP_W-1:0] gap_cnt;
    logic             scl_hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q   <= 1'b1;
            sda_q   <= 1'b1;
            gap_cnt <= GAP_W'(EARLY_GAP);
        end else if (wr_stb) begin
            scl_q   <= scl_in;
            sda_q   <= sda_in;
            gap_cnt <= GAP_W'(1);
        end else if (gap_cnt < GAP_W'(EARLY_GAP)) begin
            gap_cnt <= gap_cnt + GAP_W'(1);
        end
    end

    always_comb begin
        scl_hold  = wr_stb & scl_q & scl_in;
        evt.start = scl_hold & sda_q & ~sda_in;
        evt.stop  = scl_hold & ~sda_q & sda_in;
        evt.rise  = wr_stb & ~scl_q & scl_in;
        evt.fall  = wr_stb & scl_q & ~scl_in;
    end

    assign gap_met = (gap_cnt >= GAP_W'(EARLY_GAP));

endmodule

// File: rtl/twe_seq_engine.sv
module twe_seq_engine
    import twe_pkg::*;
#(
    parameter int MEM_AW = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  twe_mode_e          mode,
    input  line_evt_t          evt,
    input  logic               sda_in,
    output logic               started,
    output logic [CYC_W-1:0]   cyc,
    output logic               read_mode,
    output logic [MEM_AW-1:0]  mem_idx,
    output logic               mem_we
);

    logic [SLAVE_W-1:0] slave;
    logic [ADDR_W-1:0]  addr;

    logic               n_started;
    logic [CYC_W-1:0]   n_cyc;
    logic [SLAVE_W-1:0] n_slave;
    logic [ADDR_W-1:0]  n_addr;
    logic [CYC_W-1:0]   cyc_inc;
    logic [ADDR_W-1:0]  shifted;
    logic               is_legacy;
    logic               is_one;
    logic               in_data;

    assign is_legacy = (mode == MODE_LEGACY);
    assign is_one    = (mode == MODE_ONE);
    assign in_data   = (!is_legacy && !is_one && cyc > 6'd27) || (is_one && cyc > 6'd18);
    assign read_mode = is_legacy ? addr[0] : slave[0];
    assign mem_idx   = is_legacy ? MEM_AW'(addr[7:1]) : addr[MEM_AW-1:0];

    always_comb begin
        n_started = started;
        n_cyc     = cyc;
        n_slave   = slave;
        n_addr    = addr;
        mem_we    = 1'b0;
        cyc_inc   = cyc + 6'd1;
        shifted   = {addr[ADDR_W-2:0], sda_in};
        if (evt.start) begin
            n_started = 1'b1;
            n_cyc     = '0;
        end else if (evt.stop) begin
            n_started = 1'b0;
        end else if (started && evt.rise) begin
            if (is_legacy) begin
                if (cyc_inc == 6'd18) begin
                    n_cyc = 6'd9;
                    if (addr[0]) n_addr = {5'd0, addr[7:0] + 8'd2};
                end else begin
                    n_cyc = cyc_inc;
                end
            end else if (slave[0] && cyc_inc == 6'd18) begin
                n_cyc  = 6'd9;
                n_addr = addr + 13'd1;
            end else if (is_one && cyc_inc == 6'd27) begin
                n_cyc = 6'd18;
            end else if (cyc_inc == 6'd36) begin
                n_cyc = 6'd27;
            end else begin
                n_cyc = cyc_inc;
            end
        end else if (started && evt.fall) begin
            if (is_legacy) begin
                if (cyc > 6'd9) begin
                    if (!addr[0]) begin
                        mem_we = 1'b1;
                        if (cyc == 6'd17) n_addr = {5'd0, legacy_page_next(addr[7:0])};
                    end
                end else if (cyc < 6'd9) begin
                    n_addr = {5'd0, addr[6:0], sda_in};
                end
            end else if (!is_ack_slot(cyc)) begin
                if (in_data) begin
                    if (!slave[0]) begin
                        mem_we = 1'b1;
                        if (cyc == 6'd26 || cyc == 6'd35) n_addr = page16_next(addr);
                    end
                end else if (cyc > 6'd9) begin
                    if (!slave[0]) begin
                        if (is_one) begin
                            n_addr = {5'd0, shifted[7:0]};
                            if (cyc == 6'd17) n_addr[10:8] = slave[3:1];
                        end else begin
                            n_addr = shifted;
                        end
                    end
                end else begin
                    n_slave = {slave[SLAVE_W-2:0], sda_in};
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            started <= 1'b0;
            cyc     <= '0;
            slave   <= '0;
            addr    <= '0;
        end else begin
            started <= n_started;
            cyc     <= n_cyc;
            slave   <= n_slave;
            addr    <= n_addr;
        end
    end

    assert_start_clears_R1: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> (started && cyc == '0));

    assert_stop_ends_R1: assert property (@(posedge clk) disable iff (rst)
        (evt.stop && !evt.start) |=> !started);

    assert_idle_frozen_R2: assert property (@(posedge clk) disable iff (rst)
        (!started && !evt.start) |=> ($stable(cyc) && $stable(addr) && $stable(slave)));

    assert_cyc_bound_R3: assert property (@(posedge clk) disable iff (rst)
        started |-> (cyc < wrap_point(mode)));

endmodule

// File: rtl/twe_byte_store.sv
module twe_byte_store #(
    parameter int MEM_BYTES = 1024,
    localparam int MEM_AW = $clog2(MEM_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [MEM_AW-1:0] idx,
    input  logic              bit_in,
    output logic [7:0]        rd_byte
);

    logic [7:0] mem [MEM_BYTES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
        end else if (we) begin
            mem[idx] <= {mem[idx][6:0], bit_in};
        end
    end

    assign rd_byte = mem[idx];

endmodule

// File: rtl/twoline_eeprom.sv
module twoline_eeprom
    import twe_pkg::*;
#(
    parameter int MEM_BYTES = 1024,
    parameter int EARLY_GAP = 24,
    localparam int MEM_AW = $clog2(MEM_BYTES)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_sel,
    input  logic       wr_stb,
    input  logic       wr_scl,
    input  logic       wr_sda,
    input  logic       rd_stb,
    output logic       rd_data
);

    line_evt_t          evt;
    logic               scl_q;
    logic               sda_q;
    logic               gap_met;
    logic               started;
    logic [CYC_W-1:0]   cyc;
    logic               read_mode;
    logic [MEM_AW-1:0]  mem_idx;
    logic               mem_we;
    logic [7:0]         rd_byte;
    logic [CYC_W-1:0]   eff_cyc;
    logic [2:0]         bit_pos;
    logic               rd_bit;
    twe_mode_e          mode;

    assign mode = twe_mode_e'(mode_sel);

    twe_line_mon #(.EARLY_GAP(EARLY_GAP)) line_mon_i (
        .clk     (clk),
        .rst     (rst),
        .wr_stb  (wr_stb),
        .scl_in  (wr_scl),
        .sda_in  (wr_sda),
        .evt     (evt),
        .scl_q   (scl_q),
        .sda_q   (sda_q),
        .gap_met (gap_met)
    );

    twe_seq_engine #(.MEM_AW(MEM_AW)) engine_i (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .evt       (evt),
        .sda_in    (wr_sda),
        .started   (started),
        .cyc       (cyc),
        .read_mode (read_mode),
        .mem_idx   (mem_idx),
        .mem_we    (mem_we)
    );

    twe_byte_store #(.MEM_BYTES(MEM_BYTES)) store_i (
        .clk     (clk),
        .rst     (rst),
        .we      (mem_we),
        .idx     (mem_idx),
        .bit_in  (wr_sda),
        .rd_byte (rd_byte)
    );

    always_comb begin
        eff_cyc = (!scl_q && gap_met) ? cyc + 6'd1 : cyc;
        bit_pos = 3'(6'd17 - eff_cyc);
        if (!started)
            rd_bit = sda_q;
        else if (is_ack_slot(eff_cyc))
            rd_bit = 1'b0;
        else if (eff_cyc >= 6'd10 && eff_cyc <= 6'd17 && read_mode)
            rd_bit = rd_byte[bit_pos];
        else
            rd_bit = sda_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= 1'b0;
        else if (rd_stb)
            rd_data <= rd_bit;
    end

    assert_idle_echo_R12: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && !started) |=> (rd_data == $past(sda_q)));

    assert_ack_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && started && scl_q && is_ack_slot(cyc)) |=> !rd_data);

    assert_hold_R14: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> $stable(rd_data));

endmodule

// File: tb/twoline_eeprom_tb.sv
module twoline_eeprom_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int MEM_BYTES  = 1024;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode_sel = 2'd0;
    logic       wr_stb = 1'b0;
    logic       wr_scl = 1'b1;
    logic       wr_sda = 1'b1;
    logic       rd_stb = 1'b0;
    logic       rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] ref_mem [MEM_BYTES];

    always #(CLK_PERIOD/2) clk = ~clk;

    twoline_eeprom #(.MEM_BYTES(MEM_BYTES), .EARLY_GAP(24)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .mode_sel (mode_sel),
        .wr_stb   (wr_stb),
        .wr_scl   (wr_scl),
        .wr_sda   (wr_sda),
        .rd_stb   (rd_stb),
        .rd_data  (rd_data)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic put(input logic c, input logic d);
        @(negedge clk);
        wr_stb = 1'b1; wr_scl = c; wr_sda = d;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic sample(output logic b);
        @(negedge clk);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        b = rd_data;
    endtask

    task automatic do_start();
        put(1'b0, 1'b1); put(1'b1, 1'b1); put(1'b1, 1'b0);
    endtask

    task automatic do_stop();
        put(1'b0, 1'b0); put(1'b1, 1'b0); put(1'b1, 1'b1);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            put(1'b0, b[i]); put(1'b1, b[i]); put(1'b0, b[i]);
        end
    endtask

    task automatic ack_slot(input bit probe);
        logic v;
        put(1'b0, 1'b1); put(1'b1, 1'b1);
        if (probe) begin
            sample(v);
            chk("R4 ack period reads 0", {7'd0, v}, 8'h00);
        end
        put(1'b0, 1'b1);
    endtask

    task automatic recv_byte(output logic [7:0] b);
        logic v;
        for (int i = 7; i >= 0; i--) begin
            put(1'b0, 1'b1); put(1'b1, 1'b1);
            sample(v);
            b[i] = v;
            put(1'b0, 1'b1);
        end
    endtask

    function automatic int wr_index(input int m, input int a, input int i);
        if (m == 0) return ((a & ~3) | ((a + i) & 3)) & 127;
        return (((a & ~15) | ((a + i) & 15)) & 8191) & (MEM_BYTES - 1);
    endfunction

    function automatic int rd_index(input int m, input int a, input int i);
        if (m == 0) return (a + i) & 127;
        return ((a + i) & 8191) & (MEM_BYTES - 1);
    endfunction

    task automatic send_header(input int m, input int a);
        logic [12:0] av;
        av = 13'(a);
        if (m == 0) begin
            send_byte({av[6:0], 1'b0}); ack_slot(1'b0);
        end else begin
            send_byte({4'b1010, (m == 1) ? av[10:8] : 3'b000, 1'b0}); ack_slot(1'b0);
            if (m == 2) begin send_byte({3'b000, av[12:8]}); ack_slot(1'b0); end
            send_byte(av[7:0]); ack_slot(1'b0);
        end
    endtask

    task automatic xfer_write(input int m, input int a, input int n, input logic [7:0] seed_b, input bit rnd);
        logic [7:0] b;
        mode_sel = 2'(m);
        do_start();
        send_header(m, a);
        for (int i = 0; i < n; i++) begin
            b = rnd ? 8'($urandom) : 8'(seed_b + 8'(i));
            send_byte(b); ack_slot(1'b0);
            ref_mem[wr_index(m, a, i)] = b;
        end
        do_stop();
    endtask

    task automatic xfer_read(input int m, input int a, input int n, input string req);
        logic [7:0] b;
        logic [12:0] av;
        av = 13'(a);
        mode_sel = 2'(m);
        do_start();
        if (m == 0) begin
            send_byte({av[6:0], 1'b1}); ack_slot(1'b1);
        end else begin
            send_header(m, a);
            do_start();
            send_byte({4'b1010, (m == 1) ? av[10:8] : 3'b000, 1'b1}); ack_slot(1'b1);
        end
        for (int i = 0; i < n; i++) begin
            recv_byte(b);
            chk(req, b, ref_mem[rd_index(m, a, i)]);
            if (i < n - 1) begin put(1'b0, 1'b0); put(1'b1, 1'b0); put(1'b0, 1'b0); end
            else begin put(1'b0, 1'b1); put(1'b1, 1'b1); put(1'b0, 1'b1); end
        end
        do_stop();
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        logic v;
        void'($urandom(32'd91357));
        for (int i = 0; i < MEM_BYTES; i++) ref_mem[i] = 8'hFF;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R14: reset value
        chk("R14 reset value", {7'd0, rd_data}, 8'h00);
        // R12: idle echo of last posted data level
        sample(v); chk("R12 idle echo 1", {7'd0, v}, 8'h01);
        put(1'b0, 1'b0);
        sample(v); chk("R12 idle echo 0", {7'd0, v}, 8'h00);
        repeat (3) @(negedge clk);
        chk("R14 holds without strobe", {7'd0, rd_data}, 8'h00);
        put(1'b0, 1'b1);

        // R5 R6: legacy burst from word 5 folds inside the 4-byte page
        xfer_write(0, 5, 6, 8'h30, 1'b0);
        xfer_read(0, 4, 4, "R6 legacy page fold");
        // R7: legacy sequential read rolls 127 -> 0
        xfer_write(0, 127, 1, 8'h7E, 1'b0);
        xfer_write(0, 0, 1, 8'h81, 1'b0);
        xfer_read(0, 126, 4, "R7 legacy read rollover");

        // R2: clock activity without a start changes nothing
        mode_sel = 2'd0;
        send_byte(8'h0A); send_byte(8'h00); send_byte(8'h00);
        put(1'b1, 1'b1);
        xfer_read(0, 5, 2, "R2 idle clocking ignored");

        // R13: early read rule, word 40 holds A5
        xfer_write(0, 40, 1, 8'hA5, 1'b0);
        do_start();
        send_byte({7'd40, 1'b1}); ack_slot(1'b1);
        put(1'b0, 1'b1); put(1'b1, 1'b1);
        sample(v); chk("R13 normal bit7", {7'd0, v}, 8'h01);
        put(1'b0, 1'b1);
        sample(v); chk("R13 short gap keeps period", {7'd0, v}, 8'h01);
        repeat (30) @(negedge clk);
        sample(v); chk("R13 long gap reads next bit", {7'd0, v}, 8'h00);
        put(1'b1, 1'b1);
        sample(v); chk("R13 bit6 after rise", {7'd0, v}, 8'h00);
        put(1'b0, 1'b1);
        do_stop();

        // R8 R10: mode 1 block bits and 16-byte page fold
        xfer_write(1, 2 * 256 + 8'hFA, 10, 8'h50, 1'b0);
        xfer_write(1, 1 * 256 + 8'h10, 2, 8'hC0, 1'b0);
        xfer_write(1, 2 * 256 + 8'h10, 2, 8'hD0, 1'b0);
        xfer_read(1, 2 * 256 + 8'hF0, 16, "R10 mode1 page fold");
        xfer_read(1, 1 * 256 + 8'h10, 2, "R8 block bits 1");
        xfer_read(1, 2 * 256 + 8'h10, 2, "R8 block bits 2");
        // R11: read crosses a 256-byte boundary
        xfer_read(1, 1 * 256 + 8'hF8, 12, "R11 mode1 read crosses boundary");

        // R9 R3: two address bytes, long burst
        xfer_write(2, 13'h0235, 20, 8'h11, 1'b0);
        xfer_read(2, 13'h0230, 24, "R9 R3 mode2 burst");
        mode_sel = 2'd3;
        xfer_read(2, 13'h0238, 4, "R9 mode2 read");

        // random mix, all requirements via reference array (R3 R10 R11)
        for (int t = 0; t < 30; t++) begin
            int m, a, n;
            m = t % 3;
            if (m == 0) begin a = int'($urandom % 128); n = 1 + int'($urandom % 6); end
            else if (m == 1) begin a = int'($urandom % 2048); n = 1 + int'($urandom % 20); end
            else begin a = int'($urandom % 8192); n = 1 + int'($urandom % 20); end
            xfer_write(m, a, n, 8'h00, 1'b1);
            xfer_read(m, a & ~3, n + 3, "R3 random readback");
        end

        report();
    end

endmodule